// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end and internal operation sequencer of a parallel NOR flash with a 16-bit data path. A host writes command bytes on the low byte of `wdata` while `wr_en` is high for one clock. Some commands take one write and some take two. The block decodes these writes into block erase, full chip erase and word program operations. It times each operation with a loadable cycle counter and applies the result to a small behavioural word array.

A running block erase can be suspended. While it is suspended, a word program may run, and that program may be suspended in turn. The block keeps an 8-bit status word and selects what `rdata` returns: array contents, identifier codes or status. `rdy` is high whenever no internal operation is running.

The state machine has eight states:
- `ST_IDLE`: ready. A held erase may sit under this state.
- `ST_ERS_SETUP`, `ST_CHIP_SETUP`, `ST_PROG_SETUP`: the first cycle of a two-cycle command has been taken.
- `ST_ERASING`, `ST_CHIP_ERASING`, `ST_PROGRAMMING`: an operation is running.
- `ST_PROG_SUSP`: a program is parked.

Transitions:
- Setup: IDLE→setup on a first cycle.
- Start: setup→running on a valid second cycle.
- Reject: setup→IDLE on an improper sequence or an abort.
- Complete: running→IDLE when the timer expires.
- Erase suspend: ERASING→IDLE, with the erase held.
- Erase resume: IDLE→ERASING, taking the held erase.
- Program suspend: PROGRAMMING→PROG_SUSP.
- Program resume: PROG_SUSP→PROGRAMMING.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Reset aborts any running operation and leaves array contents untouched. After release, `rdy`=1, reads return array data, and the status reads 0x0080.
- R2: Command 0x90 selects identifier reads: address 0 returns 0x00B0, address 1 returns 0x00A4, and any other address returns 0x0000.
- R3: Status bits: bit7 ready, bit6 erase suspended, bit5 erase error, bit4 program error, bit3 supply-low abort, bit2 program suspended, bit1 locked-block abort. Bits 15..8 and bit 0 read 0. Error bits stay set until command 0x50, which clears bits 5, 4, 3 and 1 only.
- R4: Block erase (0x20 then 0xD0 at the same address) holds `rdy` low for ERASE_CYC cycles after the confirm edge. It then sets every word of the addressed block to 0xFFFF and leaves other blocks unchanged.
- R5: Word program (0x40, then the data at the same address) holds `rdy` low for PROG_CYC cycles. The target word then becomes old AND new, so bits only go from 1 to 0.
- R6: Chip erase (0x30 then 0xD0 at the same address) runs for CHIP_CYC cycles and erases every block whose `blk_lock` bit is 0. A suspend (0xB0) during it is ignored.
- R7: A second cycle with a different address, or an erase or chip second cycle other than 0xD0, is an improper sequence. It sets bits 5 and 4, starts nothing and leaves the array unchanged.
- R8: Erase or program aimed at a block whose `blk_lock` bit is 1 is aborted at the second cycle. The abort sets bit 1 with bit 5 (erase) or bit 4 (program), and `rdy` stays 1.
- R9: With `vsup_low`=1 at the second cycle, the operation is aborted. The abort sets bit 3 with bit 5 (erase or chip erase) or bit 4 (program).
- R10: 0xB0 during a block erase or program stops it in the next cycle with `rdy`=1. A suspended erase sets bit 6 and a suspended program sets bit 2. 0xD0 resumes the operation, and the total busy time is unchanged.
- R11: While an erase is suspended, a word program is accepted. If both are suspended, 0xD0 resumes the program first; when it completes, the erase is still suspended and the next 0xD0 resumes it.
- R12: While busy, a status read returns 0x0000 because only bit 7 is valid. Any write while busy switches reads to status mode.
- R13: 0xFF selects array reads and 0x70 selects status reads. An unrecognised first-cycle code leaves the read mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle command/data write strobe |
| addr | input | AW | Word address for writes and reads |
| wdata | input | 16 | Write data; command codes on bits 7..0 |
| blk_lock | input | NBLK | Per-block lock, 1 = locked |
| vsup_low | input | 1 | Programming supply below limit |
| rdata | output | 16 | Read data for the current read mode |
| rdy | output | 1 | High when no internal operation runs |

## Verification
The bench builds the block with four blocks of four words and short durations: erase 12, chip erase 20 and program 5 cycles. These short durations let it count every busy edge exactly, including across suspend and resume. They also let it place suspends at known counter values and run the doubly suspended erase-plus-program path to completion in a few dozen cycles. Lock and supply-low inputs are driven directly to reach every abort path.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERS_SETUP,
        ST_CHIP_SETUP,
        ST_PROG_SETUP,
        ST_ERASING,
        ST_CHIP_ERASING,
        ST_PROGRAMMING,
        ST_PROG_SUSP
    } fc_state_e;

    typedef enum logic [1:0] {
        RD_ARRAY,
        RD_IDENT,
        RD_STATUS
    } fc_rdmode_e;

    localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_RD_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
    localparam logic [7:0] CMD_BLK_ERASE = 8'h20;
    localparam logic [7:0] CMD_CHIP_ERS  = 8'h30;
    localparam logic [7:0] CMD_PROGRAM   = 8'h40;
    localparam logic [7:0] CMD_SUSPEND   = 8'hB0;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;

    localparam logic [15:0] ID_MAKER  = 16'h00B0;
    localparam logic [15:0] ID_DEVICE = 16'h00A4;

endpackage

// File: rtl/fc_timer.sv
module fc_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] dur,
    input  logic          run,
    output logic          expire
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= dur - TW'(1);
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - TW'(1);
    end

    assign expire = run && (cnt_q == '0);

    // a freshly loaded count of at least two cycles cannot expire at once (R4)
    assert_load_no_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && dur > TW'(1)) |=> !expire);

endmodule

// File: rtl/fc_array.sv
module fc_array #(
    parameter int NBLK      = 4,
    parameter int BLK_WORDS = 4,
    parameter int AW        = 4,
    parameter int BKW       = 2
) (
    input  logic                 clk,
    input  logic                 ers_blk_en,
    input  logic [BKW-1:0]       ers_blk,
    input  logic                 ers_all,
    input  logic [NBLK-1:0]      ers_mask,
    input  logic                 prog_en,
    input  logic [AW-1:0]        prog_addr,
    input  logic [15:0]          prog_data,
    input  logic [AW-1:0]        rd_addr,
    output logic [15:0]          rd_data
);

    localparam int NW = NBLK * BLK_WORDS;

    logic [NW-1:0][15:0] words;

    for (genvar i = 0; i < NW; i++) begin : g_word
        localparam int BI = i / BLK_WORDS;
        logic [15:0] word_q;
        always_ff @(posedge clk) begin
            if ((ers_all && ers_mask[BI]) || (ers_blk_en && ers_blk == BKW'(BI)))
                word_q <= 16'hFFFF;
            else if (prog_en && prog_addr == AW'(i))
                word_q <= word_q & prog_data;
        end
        assign words[i] = word_q;
    end

    assign rd_data = words[rd_addr];

    // a program commit never coincides with an erase commit (R5)
    assert_single_commit_R5: assert property (@(posedge clk)
        !(prog_en && (ers_all || ers_blk_en)));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int NBLK      = 4,
    parameter int BLK_WORDS = 4,
    parameter int ERASE_CYC = 1000,
    parameter int CHIP_CYC  = 4000,
    parameter int PROG_CYC  = 50
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        wr_en,
    input  logic [$clog2(NBLK)+$clog2(BLK_WORDS)-1:0]   addr,
    input  logic [15:0]                                 wdata,
    input  logic [NBLK-1:0]                             blk_lock,
    input  logic                                        vsup_low,
    output logic [15:0]                                 rdata,
    output logic                                        rdy
);

    localparam int BW   = $clog2(BLK_WORDS);
    localparam int BKW  = $clog2(NBLK);
    localparam int AW   = BKW + BW;
    localparam int MAXE = (CHIP_CYC > ERASE_CYC) ? CHIP_CYC : ERASE_CYC;
    localparam int MAXC = (MAXE > PROG_CYC) ? MAXE : PROG_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    fc_state_e  state_q, nxt_state;
    fc_rdmode_e mode_q;

    logic [7:0]     cmd;
    logic [BKW-1:0] addr_blk;
    logic           busy;
    logic           same_addr;

    logic [AW-1:0]  setup_addr_q;
    logic [BKW-1:0] ers_blk_q;
    logic [AW-1:0]  prog_addr_q;
    logic [15:0]    prog_data_q;
    logic           erase_held_q;
    logic           sr5_q, sr4_q, sr3_q, sr1_q;

    logic ers_load, chip_load, prog_load;
    logic ers_exp, prog_exp;
    logic ers_commit, chip_commit, prog_commit;
    logic improper, ab_lock_e, ab_lock_p, ab_vlow_e, ab_vlow_p;
    logic susp_e, resume_e;

    logic [TW-1:0] ers_dur;
    logic [15:0]   arr_rd;
    logic [15:0]   status_w;

    assign cmd       = wdata[7:0];
    assign addr_blk  = addr[AW-1:BW];
    assign same_addr = (addr == setup_addr_q);
    assign busy      = (state_q == ST_ERASING) || (state_q == ST_CHIP_ERASING) ||
                       (state_q == ST_PROGRAMMING);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt_state;
    end

    // next state and control strobes
    always_comb begin
        nxt_state   = state_q;
        ers_load    = 1'b0;
        chip_load   = 1'b0;
        prog_load   = 1'b0;
        ers_commit  = 1'b0;
        chip_commit = 1'b0;
        prog_commit = 1'b0;
        improper    = 1'b0;
        ab_lock_e   = 1'b0;
        ab_lock_p   = 1'b0;
        ab_vlow_e   = 1'b0;
        ab_vlow_p   = 1'b0;
        susp_e      = 1'b0;
        resume_e    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (wr_en) begin
                if (!erase_held_q && cmd == CMD_BLK_ERASE)      nxt_state = ST_ERS_SETUP;
                else if (!erase_held_q && cmd == CMD_CHIP_ERS)  nxt_state = ST_CHIP_SETUP;
                else if (cmd == CMD_PROGRAM)                    nxt_state = ST_PROG_SETUP;
                else if (erase_held_q && cmd == CMD_CONFIRM) begin
                    nxt_state = ST_ERASING;
                    resume_e  = 1'b1;
                end
            end
            ST_ERS_SETUP: if (wr_en) begin
                nxt_state = ST_IDLE;
                if (cmd != CMD_CONFIRM || !same_addr) improper  = 1'b1;
                else if (vsup_low)                    ab_vlow_e = 1'b1;
                else if (blk_lock[addr_blk])          ab_lock_e = 1'b1;
                else begin
                    nxt_state = ST_ERASING;
                    ers_load  = 1'b1;
                end
            end
            ST_CHIP_SETUP: if (wr_en) begin
                nxt_state = ST_IDLE;
                if (cmd != CMD_CONFIRM || !same_addr) improper  = 1'b1;
                else if (vsup_low)                    ab_vlow_e = 1'b1;
                else begin
                    nxt_state = ST_CHIP_ERASING;
                    chip_load = 1'b1;
                end
            end
            ST_PROG_SETUP: if (wr_en) begin
                nxt_state = ST_IDLE;
                if (!same_addr)               improper  = 1'b1;
                else if (vsup_low)            ab_vlow_p = 1'b1;
                else if (blk_lock[addr_blk])  ab_lock_p = 1'b1;
                else begin
                    nxt_state = ST_PROGRAMMING;
                    prog_load = 1'b1;
                end
            end
            ST_ERASING: begin
                if (ers_exp) begin
                    nxt_state  = ST_IDLE;
                    ers_commit = 1'b1;
                end else if (wr_en && cmd == CMD_SUSPEND) begin
                    nxt_state = ST_IDLE;
                    susp_e    = 1'b1;
                end
            end
            ST_CHIP_ERASING: begin
                if (ers_exp) begin
                    nxt_state   = ST_IDLE;
                    chip_commit = 1'b1;
                end
            end
            ST_PROGRAMMING: begin
                if (prog_exp) begin
                    nxt_state   = ST_IDLE;
                    prog_commit = 1'b1;
                end else if (wr_en && cmd == CMD_SUSPEND) begin
                    nxt_state = ST_PROG_SUSP;
                end
            end
            ST_PROG_SUSP: begin
                if (wr_en && cmd == CMD_CONFIRM) nxt_state = ST_PROGRAMMING;
            end
        endcase
    end

    // registered datapath: read mode, status bits, saved operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q       <= RD_ARRAY;
            setup_addr_q <= '0;
            ers_blk_q    <= '0;
            prog_addr_q  <= '0;
            prog_data_q  <= '0;
            erase_held_q <= 1'b0;
            sr5_q        <= 1'b0;
            sr4_q        <= 1'b0;
            sr3_q        <= 1'b0;
            sr1_q        <= 1'b0;
        end else begin
            if (wr_en) begin
                if (busy)
                    mode_q <= RD_STATUS;
                else if (state_q == ST_IDLE || state_q == ST_PROG_SUSP) begin
                    if (nxt_state != state_q)          mode_q <= RD_STATUS;
                    else if (cmd == CMD_RD_ARRAY)      mode_q <= RD_ARRAY;
                    else if (cmd == CMD_RD_IDENT)      mode_q <= RD_IDENT;
                    else if (cmd == CMD_RD_STATUS)     mode_q <= RD_STATUS;
                end else
                    mode_q <= RD_STATUS;
            end
            if (state_q == ST_IDLE && wr_en) setup_addr_q <= addr;
            if (ers_load) ers_blk_q <= addr_blk;
            if (state_q == ST_PROG_SETUP && wr_en) begin
                prog_addr_q <= addr;
                prog_data_q <= wdata;
            end
            if (susp_e)        erase_held_q <= 1'b1;
            else if (resume_e) erase_held_q <= 1'b0;
            if (wr_en && cmd == CMD_CLR_STAT &&
                (state_q == ST_IDLE || state_q == ST_PROG_SUSP)) begin
                sr5_q <= 1'b0;
                sr4_q <= 1'b0;
                sr3_q <= 1'b0;
                sr1_q <= 1'b0;
            end else begin
                if (improper || ab_lock_e || ab_vlow_e) sr5_q <= 1'b1;
                if (improper || ab_lock_p || ab_vlow_p) sr4_q <= 1'b1;
                if (ab_vlow_e || ab_vlow_p)             sr3_q <= 1'b1;
                if (ab_lock_e || ab_lock_p)             sr1_q <= 1'b1;
            end
        end
    end

    assign ers_dur = chip_load ? TW'(CHIP_CYC) : TW'(ERASE_CYC);

    fc_timer #(.TW(TW)) u_ers_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ers_load || chip_load),
        .dur    (ers_dur),
        .run    (state_q == ST_ERASING || state_q == ST_CHIP_ERASING),
        .expire (ers_exp)
    );

    fc_timer #(.TW(TW)) u_prog_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (prog_load),
        .dur    (TW'(PROG_CYC)),
        .run    (state_q == ST_PROGRAMMING),
        .expire (prog_exp)
    );

    fc_array #(.NBLK(NBLK), .BLK_WORDS(BLK_WORDS), .AW(AW), .BKW(BKW)) u_array (
        .clk        (clk),
        .ers_blk_en (ers_commit),
        .ers_blk    (ers_blk_q),
        .ers_all    (chip_commit),
        .ers_mask   (~blk_lock),
        .prog_en    (prog_commit),
        .prog_addr  (prog_addr_q),
        .prog_data  (prog_data_q),
        .rd_addr    (addr),
        .rd_data    (arr_rd)
    );

    // outputs
    always_comb begin
        if (busy)
            status_w = 16'h0000;
        else
            status_w = {8'h00, 1'b1, erase_held_q, sr5_q, sr4_q, sr3_q,
                        (state_q == ST_PROG_SUSP), sr1_q, 1'b0};
        rdy = !busy;
        case (mode_q)
            RD_ARRAY:  rdata = arr_rd;
            RD_IDENT:  rdata = (addr == AW'(0)) ? ID_MAKER :
                               (addr == AW'(1)) ? ID_DEVICE : 16'h0000;
            RD_STATUS: rdata = status_w;
            default:   rdata = 16'h0000;
        endcase
    end

    assert_busy_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && $past(rdy)) |-> $past(wr_en));

    assert_chip_no_suspend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHIP_ERASING && wr_en && cmd == CMD_SUSPEND && !ers_exp)
        |=> (state_q == ST_CHIP_ERASING));

    assert_lock_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERS_SETUP && wr_en && cmd == CMD_CONFIRM && same_addr &&
         !vsup_low && blk_lock[addr_blk]) |=> (rdy && sr1_q && sr5_q));

    assert_error_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sr5_q && !(wr_en && cmd == CMD_CLR_STAT)) |=> sr5_q);

    assert_resume_prog_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG_SUSP && wr_en && cmd == CMD_CONFIRM)
        |=> (state_q == ST_PROGRAMMING && erase_held_q == $past(erase_held_q)));

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;

    localparam int NBLK = 4, BLK_WORDS = 4, AW = 4;
    localparam int ERS = 12, CHIP = 20, PRG = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [NBLK-1:0] blk_lock = '0;
    logic          vsup_low = 1'b0;
    logic [15:0]   rdata;
    logic          rdy;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] d;
        logic        r;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    flash_cmd_ctrl #(.NBLK(NBLK), .BLK_WORDS(BLK_WORDS), .ERASE_CYC(ERS),
                     .CHIP_CYC(CHIP), .PROG_CYC(PRG)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .blk_lock(blk_lock), .vsup_low(vsup_low), .rdata(rdata), .rdy(rdy));

    // monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (rdata !== e.d || rdy !== e.r) begin
                n_fail++;
                $display("FAIL %s: rdata=%h rdy=%b expected rdata=%h rdy=%b",
                         e.tag, rdata, rdy, e.d, e.r);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_rd(input logic [AW-1:0] a, input logic [15:0] d,
                             input logic r, input string tag);
        exp_t e;
        addr = a;
        e.d = d; e.r = r; e.tag = tag;
        sb.push_back(e);
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        wr(0, 16'h0070);
        expect_rd(0, 16'h0080, 1'b1, "R1 status after reset");

        // R6 chip erase to initialise, R12 masking while busy
        wr(0, 16'h0030); wr(0, 16'h00D0);
        expect_rd(0, 16'h0000, 1'b0, "R12 status masked while busy");
        idle(CHIP - 1);
        expect_rd(0, 16'h0000, 1'b0, "R6 chip erase still busy");
        idle(1);
        expect_rd(0, 16'h0080, 1'b1, "R6 chip erase done");
        wr(0, 16'h00FF);
        expect_rd(5, 16'hFFFF, 1'b1, "R6 word erased");
        wr(0, 16'h0012);
        expect_rd(5, 16'hFFFF, 1'b1, "R13 unknown code keeps array mode");

        // R2 identifier
        wr(0, 16'h0090);
        expect_rd(0, 16'h00B0, 1'b1, "R2 maker code");
        expect_rd(1, 16'h00A4, 1'b1, "R2 device code");
        expect_rd(2, 16'h0000, 1'b1, "R2 other offset");
        wr(0, 16'h0033);
        expect_rd(1, 16'h00A4, 1'b1, "R13 unknown code keeps ident mode");

        // R5 program with exact timing
        wr(5, 16'h0040); wr(5, 16'h1234);
        expect_rd(5, 16'h0000, 1'b0, "R12 program busy");
        idle(PRG - 1);
        expect_rd(5, 16'h0000, 1'b0, "R5 still busy at last cycle");
        idle(1);
        expect_rd(5, 16'h0080, 1'b1, "R5 program done");
        wr(5, 16'h0040); wr(5, 16'hFF0F); idle(PRG);
        wr(0, 16'h00FF);
        expect_rd(5, 16'h1204, 1'b1, "R5 AND of old and new");
        wr(9, 16'h0040); wr(9, 16'h5A5A); idle(PRG);

        // R12 write during busy switches to status
        wr(0, 16'h00FF);
        wr(6, 16'h0040); wr(6, 16'h0000);
        wr(0, 16'h00FF);
        expect_rd(6, 16'h0000, 1'b0, "R12 read-array write while busy gives status");
        idle(PRG - 1);
        expect_rd(6, 16'h0080, 1'b1, "R12 ready after program");

        // R4 block erase of block 1
        wr(4, 16'h0020); wr(4, 16'h00D0);
        idle(ERS - 1);
        expect_rd(0, 16'h0000, 1'b0, "R4 busy through last cycle");
        idle(1);
        expect_rd(0, 16'h0080, 1'b1, "R4 ready after erase");
        wr(0, 16'h00FF);
        expect_rd(5, 16'hFFFF, 1'b1, "R4 block word erased");
        expect_rd(6, 16'hFFFF, 1'b1, "R4 block word erased");
        expect_rd(9, 16'h5A5A, 1'b1, "R4 other block kept");

        // R7 improper sequences, R3 stickiness and clear
        wr(8, 16'h0020); wr(12, 16'h00D0);
        expect_rd(0, 16'h00B0, 1'b1, "R7 address mismatch");
        wr(0, 16'h00FF);
        expect_rd(9, 16'h5A5A, 1'b1, "R7 no erase performed");
        wr(0, 16'h0070);
        expect_rd(0, 16'h00B0, 1'b1, "R3 error bits sticky");
        wr(0, 16'h0050);
        expect_rd(0, 16'h0080, 1'b1, "R3 clear status");
        wr(8, 16'h0020); wr(8, 16'h00FF);
        expect_rd(0, 16'h00B0, 1'b1, "R7 wrong second code");
        wr(0, 16'h0050);

        // R8 locked block
        blk_lock = 4'b0100;
        wr(8, 16'h0020); wr(8, 16'h00D0);
        expect_rd(0, 16'h00A2, 1'b1, "R8 erase on locked block");
        wr(0, 16'h00FF);
        expect_rd(9, 16'h5A5A, 1'b1, "R8 locked block unchanged");
        wr(0, 16'h0050);
        wr(9, 16'h0040); wr(9, 16'h0000);
        expect_rd(0, 16'h0092, 1'b1, "R8 program on locked block");
        wr(0, 16'h00FF);
        expect_rd(9, 16'h5A5A, 1'b1, "R8 locked word unchanged");
        wr(0, 16'h0050);
        blk_lock = 4'b0000;

        // R9 supply low
        vsup_low = 1'b1;
        wr(4, 16'h0040); wr(4, 16'h0000);
        expect_rd(0, 16'h0098, 1'b1, "R9 program aborted");
        wr(0, 16'h0050);
        wr(4, 16'h0020); wr(4, 16'h00D0);
        expect_rd(0, 16'h00A8, 1'b1, "R9 erase aborted");
        vsup_low = 1'b0;
        wr(0, 16'h0050);

        // R10 erase suspend and resume
        wr(5, 16'h0040); wr(5, 16'h0F0F); idle(PRG);
        wr(4, 16'h0020); wr(4, 16'h00D0);
        idle(3);
        wr(0, 16'h00B0);
        expect_rd(0, 16'h00C0, 1'b1, "R10 erase suspended");
        wr(0, 16'h00FF);
        expect_rd(5, 16'h0F0F, 1'b1, "R10 erase not applied while suspended");
        wr(5, 16'h0040); wr(6, 16'h0000);
        expect_rd(0, 16'h00F0, 1'b1, "R7 improper during suspend");
        wr(0, 16'h0050);
        expect_rd(0, 16'h00C0, 1'b1, "R3 clear keeps suspend bit");
        wr(0, 16'h00D0);
        expect_rd(0, 16'h0000, 1'b0, "R10 resumed busy");
        idle(ERS - 5);
        expect_rd(0, 16'h0000, 1'b0, "R10 remaining time kept");
        idle(1);
        expect_rd(0, 16'h0080, 1'b1, "R10 erase finished");
        wr(0, 16'h00FF);
        expect_rd(5, 16'hFFFF, 1'b1, "R10 erase applied");

        // R11 nested suspend
        wr(4, 16'h0040); wr(4, 16'h1111); idle(PRG);
        wr(4, 16'h0020); wr(4, 16'h00D0);
        idle(2);
        wr(0, 16'h00B0);
        wr(13, 16'h0040); wr(13, 16'h3C3C);
        idle(1);
        wr(0, 16'h00B0);
        expect_rd(0, 16'h00C4, 1'b1, "R11 both suspended");
        wr(0, 16'h00D0);
        expect_rd(0, 16'h0000, 1'b0, "R11 program resumed");
        idle(2);
        expect_rd(0, 16'h0000, 1'b0, "R11 program still running");
        idle(1);
        expect_rd(0, 16'h00C0, 1'b1, "R11 back to erase suspended");
        wr(0, 16'h00FF);
        expect_rd(13, 16'h3C3C, 1'b1, "R11 program done");
        expect_rd(4, 16'h1111, 1'b1, "R11 erase still pending");
        wr(0, 16'h00D0);
        idle(8);
        expect_rd(0, 16'h0000, 1'b0, "R11 erase resumed");
        idle(1);
        expect_rd(0, 16'h0080, 1'b1, "R11 erase finished");
        wr(0, 16'h00FF);
        expect_rd(4, 16'hFFFF, 1'b1, "R11 erase applied");

        // R6 suspend ignored and locked block skipped
        wr(9, 16'h0040); wr(9, 16'h0000); idle(PRG);
        blk_lock = 4'b1000;
        wr(0, 16'h0030); wr(0, 16'h00D0);
        idle(2);
        wr(0, 16'h00B0);
        expect_rd(0, 16'h0000, 1'b0, "R6 suspend ignored");
        idle(CHIP - 4);
        expect_rd(0, 16'h0000, 1'b0, "R6 full duration");
        idle(1);
        expect_rd(0, 16'h0080, 1'b1, "R6 chip erase done");
        wr(0, 16'h00FF);
        expect_rd(13, 16'h3C3C, 1'b1, "R6 locked block kept");
        expect_rd(9, 16'hFFFF, 1'b1, "R6 unlocked block erased");
        blk_lock = 4'b0000;

        // R10 program suspend
        wr(1, 16'h0040); wr(1, 16'h00FF);
        wr(0, 16'h00B0);
        expect_rd(0, 16'h0084, 1'b1, "R10 program suspended");
        wr(0, 16'h00D0);
        idle(PRG);
        expect_rd(0, 16'h0080, 1'b1, "R10 program resumed and done");

        // R1 reset aborts erase
        wr(2, 16'h0040); wr(2, 16'hABCD); idle(PRG);
        wr(0, 16'h0020); wr(0, 16'h00D0);
        idle(3);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        expect_rd(2, 16'hABCD, 1'b1, "R1 reset aborts erase, array mode");
        wr(0, 16'h0070);
        expect_rd(0, 16'h0080, 1'b1, "R1 status clean after reset");

        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule